// File: doc/BRIEF.md
# Serial interrupt host controller

This block is the host end of a single-wire, shared, open-drain serial interrupt line. Each cycle begins with a start frame. The host drives the line low and then high, and then releases it. Next come twenty-one data frames, three clocks each. A peripheral that wants to report a level pulls the line low in the first clock of its own frame, and the host samples the line in that clock. The cycle closes with a stop frame whose length tells every device how the next cycle will begin.

Each sampled level is turned into an active-high request bit in a parallel vector, one bit per slot. The slot kind sets the polarity. Legacy edge-style interrupt slots report the line level as it is. The non-maskable-type, channel-check and four shared PCI interrupt slots are active-low, so the level is inverted. Three slots carry interrupts that are produced elsewhere in the chip, so their bits are never taken from the stream. When the stop frame is long, the host starts the next cycle on its own after a short idle gap. When the stop frame is short, the line stays idle until a peripheral pulls it low or the local wake input is raised.

Top module: `sirq_host`

## Requirements
- R1: Synchronous reset releases the line, clears every bit of `irq_vec`, and selects continuous mode, so that a start frame follows within a few clocks of reset release.
- R2: A start frame drives the line low for exactly 4 clocks, then drives it high for 1 clock, then releases it.
- R3: After the start frame come 21 frames of 3 clocks each, and the host releases the line through all of them. Counting the first low start clock as clock 0, slot s is sampled only at the end of clock 5+3s, and bit s of `irq_vec` belongs to slot s.
- R4: In slots 1, 3 to 7, 9 to 12, 14 and 15, the bit takes the sampled level: high means requested and low means not requested.
- R5: In slot 2 (system management), slot 16 (channel check) and slots 17 to 20 (shared PCI interrupts A to D), the bit takes the inverted sample, so a low line means asserted.
- R6: Bits 0, 8 and 13 stay 0 whatever the line carries in those slots.
- R7: After slot 20 the host drives the line low for 3 clocks when `stop_long` is 1, or for 2 clocks when it is 0. It then drives the line high for 1 clock and releases it. `stop_long` is read in the last clock of slot 20.
- R8: After a 3-clock stop frame (continuous mode), the host starts the next cycle after exactly 2 released idle clocks, and a low line during those clocks has no effect on that timing.
- R9: After a 2-clock stop frame (quiet mode), no start frame begins until `wake` is high or the line is low in an idle clock. The start frame then begins in the next clock.
- R10: A bit of `irq_vec` changes only at the clock edge that ends its own slot's sample clock, and it holds its value across the rest of the cycle and between cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | 1 | Level of the shared serial interrupt line (already synchronised) |
| line_oe | output | 1 | High while the host drives the line |
| line_out | output | 1 | Level the host drives when `line_oe` is high |
| stop_long | input | 1 | 1 selects a 3-clock stop frame (continuous), 0 selects 2 clocks (quiet) |
| wake | input | 1 | Local request to start a cycle while in quiet mode |
| irq_vec | output | 21 | Decoded active-high request per slot, bit s for slot s |

## Verification
A sequencer whose slot or phase count drifts by one clock shows up in the first cycle. The request bits then line up with the wrong slot, and the stop frame starts early or late. The bench therefore checks a bit just before and just after its own sampling edge, and it checks the whole vector against patterns whose active-high and active-low slots disagree. A mode register that latches the wrong value shows up within the next idle stretch, either as a start frame after a short stop or as a gap other than two clocks after a long one. A polarity table that is wrong for a slot shows up as one wrong bit after a single cycle.

// File: rtl/sirq_pkg.sv
package sirq_pkg;

    localparam int NUM_SLOTS   = 21;
    localparam int START_LOW   = 4;
    localparam int FRAME_CLKS  = 3;
    localparam int IDLE_GAP    = 2;
    localparam int STOP_SHORT  = 2;
    localparam int STOP_LONG   = 3;

    // slot positions whose polarity or handling is special
    localparam int SLOT_SMI      = 2;
    localparam int SLOT_CHK      = 16;
    localparam int SLOT_PCI_BASE = 17;
    localparam int PCI_COUNT     = 4;
    localparam int SLOT_TIMER    = 0;
    localparam int SLOT_RTC      = 8;
    localparam int SLOT_FPU      = 13;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    localparam int CNT_MAX = max_of(max_of(START_LOW, STOP_LONG), IDLE_GAP);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam int RUN_W   = CNT_W + 1;
    localparam int PH_W    = $clog2(FRAME_CLKS);

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_START,
        SQ_START_HI,
        SQ_FRAME,
        SQ_STOP,
        SQ_STOP_HI
    } sq_state_t;

    typedef enum logic [1:0] {
        SK_ACTIVE_HIGH,
        SK_ACTIVE_LOW,
        SK_IGNORED
    } slot_kind_t;

    typedef struct packed {
        logic oe;
        logic lvl;
    } drive_t;

    function automatic slot_kind_t slot_kind(input int idx);
        if (idx == SLOT_TIMER || idx == SLOT_RTC || idx == SLOT_FPU)
            return SK_IGNORED;
        if (idx == SLOT_SMI || idx == SLOT_CHK)
            return SK_ACTIVE_LOW;
        if (idx >= SLOT_PCI_BASE && idx < SLOT_PCI_BASE + PCI_COUNT)
            return SK_ACTIVE_LOW;
        return SK_ACTIVE_HIGH;
    endfunction

endpackage

// File: rtl/sirq_seq.sv
module sirq_seq
    import sirq_pkg::*;
#(
    parameter int SLOTS  = NUM_SLOTS,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic              wake,
    input  logic              stop_long,
    output drive_t            drv,
    output logic              samp_en,
    output logic [SLOT_W-1:0] samp_slot
);

    localparam logic [CNT_W-1:0]  START_LAST = CNT_W'(START_LOW - 1);
    localparam logic [CNT_W-1:0]  GAP_LAST   = CNT_W'(IDLE_GAP - 1);
    localparam logic [CNT_W-1:0]  SHORT_LAST = CNT_W'(STOP_SHORT - 1);
    localparam logic [CNT_W-1:0]  LONG_LAST  = CNT_W'(STOP_LONG - 1);
    localparam logic [PH_W-1:0]   PH_LAST    = PH_W'(FRAME_CLKS - 1);
    localparam logic [SLOT_W-1:0] SLOT_LAST  = SLOT_W'(SLOTS - 1);

    sq_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [PH_W-1:0]   phase;
    logic [SLOT_W-1:0] slot;
    logic              cont_mode;
    logic              idle_go;

    // continuous: fixed gap; quiet: any low on the idle line or a local wake
    always_comb begin
        if (cont_mode) idle_go = (cnt == GAP_LAST);
        else           idle_go = wake || !line_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cnt       <= '0;
            phase     <= '0;
            slot      <= '0;
            cont_mode <= 1'b1;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (idle_go) begin
                        state <= SQ_START;
                        cnt   <= '0;
                    end else if (cnt != GAP_LAST) begin
                        cnt <= cnt + 1'b1;
                    end
                end
                SQ_START: begin
                    if (cnt == START_LAST) state <= SQ_START_HI;
                    else                   cnt   <= cnt + 1'b1;
                end
                SQ_START_HI: begin
                    state <= SQ_FRAME;
                    slot  <= '0;
                    phase <= '0;
                end
                SQ_FRAME: begin
                    if (phase == PH_LAST) begin
                        phase <= '0;
                        if (slot == SLOT_LAST) begin
                            state     <= SQ_STOP;
                            cnt       <= '0;
                            cont_mode <= stop_long;
                        end else begin
                            slot <= slot + 1'b1;
                        end
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                SQ_STOP: begin
                    if (cnt == (cont_mode ? LONG_LAST : SHORT_LAST))
                        state <= SQ_STOP_HI;
                    else
                        cnt <= cnt + 1'b1;
                end
                SQ_STOP_HI: begin
                    state <= SQ_IDLE;
                    cnt   <= '0;
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

    always_comb begin
        drv = '{oe: 1'b0, lvl: 1'b1};
        unique case (state)
            SQ_START, SQ_STOP:        drv = '{oe: 1'b1, lvl: 1'b0};
            SQ_START_HI, SQ_STOP_HI:  drv = '{oe: 1'b1, lvl: 1'b1};
            default:                  drv = '{oe: 1'b0, lvl: 1'b1};
        endcase
    end

    assign samp_en   = (state == SQ_FRAME) && (phase == '0);
    assign samp_slot = slot;

    // run length of host-driven low clocks, kept only for the checks below
    logic [RUN_W-1:0] low_run;
    always_ff @(posedge clk) begin
        if (rst)                       low_run <= '0;
        else if (drv.oe && !drv.lvl)   low_run <= (low_run == '1) ? low_run : low_run + 1'b1;
        else                           low_run <= '0;
    end

    p_start_len_r2: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_START_HI) |-> (low_run == RUN_W'(START_LOW)));

    p_stop_len_r7: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_STOP_HI) |-> (low_run == (cont_mode ? RUN_W'(STOP_LONG) : RUN_W'(STOP_SHORT))));

    p_quiet_wait_r9: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && !cont_mode && !wake && line_in) |=> (state == SQ_IDLE));

    p_cont_gap_r8: assert property (@(posedge clk) disable iff (rst)
        (state == SQ_IDLE && cont_mode && cnt != GAP_LAST) |=> (state == SQ_IDLE));

endmodule

// File: rtl/sirq_decode.sv
module sirq_decode
    import sirq_pkg::*;
#(
    parameter int SLOTS  = NUM_SLOTS,
    parameter int SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_in,
    input  logic              samp_en,
    input  logic [SLOT_W-1:0] samp_slot,
    output logic [SLOTS-1:0]  req
);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        localparam slot_kind_t KIND = slot_kind(g);
        if (KIND == SK_IGNORED) begin : g_ign
            assign req[g] = 1'b0;
        end else begin : g_live
            logic hit;
            assign hit = samp_en && (samp_slot == SLOT_W'(g));
            always_ff @(posedge clk) begin
                if (rst)      req[g] <= 1'b0;
                else if (hit) req[g] <= (KIND == SK_ACTIVE_LOW) ? !line_in : line_in;
            end
        end
    end

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !$past(samp_en) |-> $stable(req));

    p_single_bit_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(req ^ $past(req)) <= 1);

    p_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        (samp_en && slot_kind(int'(samp_slot)) == SK_IGNORED) |=> $stable(req));

endmodule

// File: rtl/sirq_host.sv
module sirq_host
    import sirq_pkg::*;
#(
    parameter int SLOTS = NUM_SLOTS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_in,
    output logic             line_oe,
    output logic             line_out,
    input  logic             stop_long,
    input  logic             wake,
    output logic [SLOTS-1:0] irq_vec
);

    localparam int SLOT_W = $clog2(SLOTS);

    drive_t            drv;
    logic              samp_en;
    logic [SLOT_W-1:0] samp_slot;

    sirq_seq #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .wake      (wake),
        .stop_long (stop_long),
        .drv       (drv),
        .samp_en   (samp_en),
        .samp_slot (samp_slot)
    );

    sirq_decode #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_dec (
        .clk       (clk),
        .rst       (rst),
        .line_in   (line_in),
        .samp_en   (samp_en),
        .samp_slot (samp_slot),
        .req       (irq_vec)
    );

    assign line_oe  = drv.oe;
    assign line_out = drv.lvl;

endmodule

// File: tb/tb_sirq_host.sv
`timescale 1ns/1ps
module tb_sirq_host;

    localparam logic [20:0] M_HIGH = 21'h00DEFA;
    localparam logic [20:0] M_LOW  = 21'h1F0004;
    localparam logic [20:0] M_IGN  = 21'h002101;

    localparam int NV = 4;
    localparam logic [20:0] PAT [NV] = '{21'h1FFFFF, 21'h000000, 21'h0A5A5A, 21'h012345};
    localparam logic [20:0] EXP [NV] = '{21'h00DEFA, 21'h1F0004, 21'h155A5E, 21'h1E0240};
    localparam bit          LNG [NV] = '{1'b1, 1'b1, 1'b1, 1'b0};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        periph = 1'b1;
    logic        stop_long = 1'b1;
    logic        wake = 1'b0;
    logic        line_oe, line_out, line_in;
    logic [20:0] irq_vec;
    logic [20:0] prev_vec = '0;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    assign line_in = line_oe ? line_out : periph;

    sirq_host dut (
        .clk(clk), .rst(rst), .line_in(line_in), .line_oe(line_oe),
        .line_out(line_out), .stop_long(stop_long), .wake(wake), .irq_vec(irq_vec)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // entered at the negedge of the first low start clock
    task automatic run_cycle(input logic [20:0] pat, input logic [20:0] expv, input bit lng);
        for (int k = 0; k < 68; k++) begin
            if (k > 0) @(negedge clk);
            periph = 1'b1;
            if (k >= 5 && ((k - 5) % 3) == 0) periph = pat[(k - 5) / 3];
            if (k < 4)       chk(line_oe && !line_out, "R2 start low", {line_oe, line_out}, 2'b10);
            else if (k == 4) chk(line_oe && line_out, "R2 start high", {line_oe, line_out}, 2'b11);
            else             chk(!line_oe, "R3 released in frames", line_oe, 0);
            if (k == 20) chk(irq_vec[5] == prev_vec[5], "R10 bit held before its edge", irq_vec[5], prev_vec[5]);
            if (k == 21) chk(irq_vec[5] == expv[5], "R10 bit updated at its edge", irq_vec[5], expv[5]);
        end
        for (int i = 0; i < (lng ? 3 : 2); i++) begin
            @(negedge clk);
            periph = 1'b1;
            chk(line_oe && !line_out, "R7 stop low", {line_oe, line_out}, 2'b10);
        end
        @(negedge clk);
        chk(line_oe && line_out, "R7 stop high", {line_oe, line_out}, 2'b11);
        @(negedge clk);
        chk(!line_oe, "R7 released after stop", line_oe, 0);
        chk((irq_vec & M_HIGH) == (expv & M_HIGH), "R4 active-high slots", irq_vec & M_HIGH, expv & M_HIGH);
        chk((irq_vec & M_LOW) == (expv & M_LOW), "R5 active-low slots", irq_vec & M_LOW, expv & M_LOW);
        chk((irq_vec & M_IGN) == '0, "R6 ignored slots", irq_vec & M_IGN, 0);
        prev_vec = expv;
    endtask

    // entered at the negedge of the first idle clock after a long stop
    task automatic cont_gap();
        int idle = 1;
        periph = 1'b0;
        for (int n = 0; n < 10; n++) begin
            @(negedge clk);
            periph = 1'b1;
            if (line_oe) break;
            idle++;
        end
        chk(idle == 2 && line_oe && !line_out, "R8 idle gap", idle, 2);
    endtask

    task automatic quiet_wait(input bit use_wake);
        bit stray = 1'b0;
        for (int n = 0; n < 20; n++) begin
            @(negedge clk);
            if (line_oe) stray = 1'b1;
        end
        chk(!stray, "R9 no start while quiet", stray, 0);
        if (use_wake) wake = 1'b1;
        else          periph = 1'b0;
        @(negedge clk);
        wake = 1'b0;
        periph = 1'b1;
        chk(line_oe && !line_out, "R9 start after request", {line_oe, line_out}, 2'b10);
    endtask

    initial begin
        bit found = 1'b0;
        repeat (4) @(negedge clk);
        chk(!line_oe, "R1 line released in reset", line_oe, 0);
        chk(irq_vec == '0, "R1 vector clear", irq_vec, 0);
        rst = 1'b0;
        for (int n = 0; n < 4; n++) begin
            @(negedge clk);
            if (line_oe && !line_out) begin found = 1'b1; break; end
        end
        chk(found, "R1 start after reset", found, 1);

        for (int i = 0; i < NV; i++) begin
            stop_long = LNG[i];
            run_cycle(PAT[i], EXP[i], LNG[i]);
            if (LNG[i]) cont_gap();
            else        quiet_wait(1'b0);
        end

        stop_long = 1'b0;
        run_cycle(21'h000000, 21'h1F0004, 1'b0);
        quiet_wait(1'b1);
        stop_long = 1'b1;
        run_cycle(21'h1FFFFF, 21'h00DEFA, 1'b1);
        cont_gap();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule